// File: doc/BRIEF.md
# Congestion-Delaying Route Search Switch

This block is one switch cell of a route-search fabric built in hardware. A search token, a level held at one, enters on one of the sink-side ports and is offered to every parent-side link of the cell. Each link remembers whether it is occupied, which sink-side port it is connected to, whether it belongs to a protected net, and whether it was claimed during the search of the current net. A link that is free, or whose connection already matches the port the token came from, passes the token upward one cycle later. A link set for a different port passes it only after a fixed penalty delay. The path that crosses the fewest conflicting switches therefore reaches the crossover first. A protected link that conflicts never passes the token, so it can never become a rip-up victim.

When the chosen path is committed, an allocate pulse returns down the selected parent link. It latches the new connection and sets the per-net claim bit in the same cycle. One cycle later it is passed on to the chosen sink-side port. For fanout nets the claim bit lets a later destination of the same net find a link it can reuse. A new-net pulse clears every claim bit, and a release pulse frees a link that has been ripped up.

Top module: `rsw_cell`

## Requirements
- R1: After reset every link is free, unprotected and unclaimed, and `up_tok`, `reuse_out` and `alloc_out` are all zero.
- R2: A free link drives `up_tok` high exactly one cycle after any bit of `srch_in` is high, and low one cycle after all bits are low.
- R3: An occupied link whose stored port equals the index of a high `srch_in` bit forwards the token with a latency of one cycle.
- R4: An occupied, unprotected link whose stored port differs from every high `srch_in` bit forwards the token PENALTY cycles after the request (PENALTY = 3 by default).
- R5: An occupied, protected link whose stored port differs from every high `srch_in` bit never drives its `up_tok` bit.
- R6: `alloc_in[u]` high for one cycle makes link u occupied, stores `alloc_port` as its port and `alloc_lock` as its protection flag, and sets its claim bit, all at the same clock edge.
- R7: `alloc_out[p]` is high for exactly the cycle after `alloc_in` is high with `alloc_port` = p. It has at most one bit set.
- R8: `new_net` clears the claim bit of every link. A link that receives `alloc_in` in the same cycle ends with its claim bit set.
- R9: `reuse_out[u]` is high one cycle after link u is occupied with its claim bit set, `srch_in` is high at its stored port, and `srch_clean` is high.
- R10: `rel_in[u]` frees link u and clears its protection flag, but leaves its claim bit unchanged. An allocate on the same link in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| srch_in | input | NDN | Search token level from each sink-side port |
| srch_clean | input | 1 | Token has crossed no congestion below this cell |
| alloc_in | input | NUP | Allocate pulse returning on each parent link |
| alloc_port | input | PW | Sink-side port to connect the allocated link to |
| alloc_lock | input | 1 | Allocated link belongs to a protected net |
| rel_in | input | NUP | Release (rip-up) pulse per parent link |
| new_net | input | 1 | Start of routing for a new net |
| up_tok | output | NUP | Token forwarded on each parent link |
| reuse_out | output | NUP | Link is a reusable path of the current net |
| alloc_out | output | NDN | Allocate pulse forwarded to a sink-side port |

## Verification
Two pairs of functions can fall in the same clock edge: a new-net clear with an allocate, and a release with an allocate on the same link. The bench provokes both by driving the pulses together in one cycle. It then judges the outcome through later searches, using `reuse_out` to show the claim bit and the token delay to show the occupied state. Its behavioural model applies the priorities of R8 and R10 and is compared with every output on every clock. The model holds its own delay history for each link, so a penalty path that is still in flight while the state changes is judged as well.

// File: rtl/rsw_pkg.sv
// Shared types for the route search switch.
// Assumes no cell has more than 2**SEL_MAX sink-side ports.
package rsw_pkg;
    localparam int SEL_MAX = 4;

    // State kept for one parent-side link.
    typedef struct packed {
        logic               occ;   // link is set for some net
        logic               lock;  // link belongs to a protected net
        logic               mine;  // claimed during the current net
        logic [SEL_MAX-1:0] sel;   // sink-side port it is connected to
    } link_st_t;

    // One-hot decode of a port index into an NDN-wide mask.
    function automatic logic [15:0] port_mask(input logic [SEL_MAX-1:0] idx);
        logic [15:0] m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/rsw_delay.sv
// Token latency stage for one parent link.
// Forwards a fast candidate after 1 cycle and a slow (conflicting)
// candidate after DEPTH cycles. Assumes DEPTH >= 2.
module rsw_delay #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_cand,
    input  logic slow_cand,
    output logic tok_out
);
    logic             fast_q;
    logic [DEPTH-1:0] slow_sr;

    // Register the fast path: one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) fast_q <= 1'b0;
        else        fast_q <= fast_cand;
    end

    // Shift the slow path through DEPTH stages.
    always_ff @(posedge clk) begin
        if (!rst_n) slow_sr <= '0;
        else        slow_sr <= {slow_sr[DEPTH-2:0], slow_cand};
    end

    // Merge the two paths onto the link output.
    always_comb tok_out = fast_q | slow_sr[DEPTH-1];

    // R2/R3: a fast candidate always shows up on the next cycle.
    p_fast_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fast_cand |=> tok_out);
endmodule

// File: rtl/rsw_link.sv
// State and candidate classification for one parent-side link.
// Holds occupancy, port setting, protection and claim bit.
// Assumes alloc_port < NDN.
module rsw_link
    import rsw_pkg::*;
#(
    parameter int NDN = 2,
    parameter int PW  = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NDN-1:0] srch_in,
    input  logic           srch_clean,
    input  logic           alloc,
    input  logic [PW-1:0]  alloc_port,
    input  logic           alloc_lock,
    input  logic           rel,
    input  logic           new_net,
    output logic           fast_cand,
    output logic           slow_cand,
    output logic           reuse_q
);
    link_st_t       st;
    logic [NDN-1:0] sel_mask;
    logic           tok_match;
    logic           tok_other;
    logic [15:0]    full_mask;

    // Decode the stored port into a mask over the sink-side ports.
    always_comb begin
        full_mask = port_mask(st.sel);
        sel_mask  = full_mask[NDN-1:0];
        tok_match = |(srch_in & sel_mask);
        tok_other = |(srch_in & ~sel_mask);
    end

    // Classify the token: free or agreeing is fast, conflicting is slow.
    always_comb begin
        if (!st.occ) begin
            fast_cand = |srch_in;
            slow_cand = 1'b0;
        end else begin
            fast_cand = tok_match;
            slow_cand = tok_other && !tok_match && !st.lock;
        end
    end

    // Update link state; an allocate wins over release and new-net.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '0;
        end else if (alloc) begin
            st.occ  <= 1'b1;
            st.lock <= alloc_lock;
            st.mine <= 1'b1;
            st.sel  <= SEL_MAX'(alloc_port);
        end else begin
            if (rel) begin
                st.occ  <= 1'b0;
                st.lock <= 1'b0;
            end
            if (new_net) st.mine <= 1'b0;
        end
    end

    // Report a reusable path of the current net.
    always_ff @(posedge clk) begin
        if (!rst_n) reuse_q <= 1'b0;
        else        reuse_q <= st.occ && st.mine && tok_match && srch_clean;
    end

    p_alloc_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |=> (st.occ && st.mine && st.lock == $past(alloc_lock)));

    p_newnet_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (new_net && !alloc) |=> !st.mine);

    p_reuse_needs_claim_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reuse_q |-> $past(st.mine && st.occ));

    p_lock_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st.occ && st.lock) |-> !slow_cand);

    p_release_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rel && !alloc) |=> (!st.occ && !st.lock));
endmodule

// File: rtl/rsw_cell.sv
// Route search switch cell: NDN sink-side ports, NUP parent links.
// A token on a sink-side port is forwarded up each link with latency
// 1 (free or agreeing) or PENALTY (conflicting, unprotected). An
// allocate pulse latches the link and is passed down one cycle later.
// Assumes at most one alloc_in bit is high per cycle.
module rsw_cell #(
    parameter int NDN     = 2,
    parameter int NUP     = 2,
    parameter int PENALTY = 3,
    localparam int PW     = (NDN > 1) ? $clog2(NDN) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NDN-1:0] srch_in,
    input  logic           srch_clean,
    input  logic [NUP-1:0] alloc_in,
    input  logic [PW-1:0]  alloc_port,
    input  logic           alloc_lock,
    input  logic [NUP-1:0] rel_in,
    input  logic           new_net,
    output logic [NUP-1:0] up_tok,
    output logic [NUP-1:0] reuse_out,
    output logic [NDN-1:0] alloc_out
);
    logic [NUP-1:0] fast_c;
    logic [NUP-1:0] slow_c;

    // One link state and one latency stage per parent link.
    for (genvar u = 0; u < NUP; u++) begin : g_link
        rsw_link #(.NDN(NDN), .PW(PW)) u_link (
            .clk        (clk),
            .rst_n      (rst_n),
            .srch_in    (srch_in),
            .srch_clean (srch_clean),
            .alloc      (alloc_in[u]),
            .alloc_port (alloc_port),
            .alloc_lock (alloc_lock),
            .rel        (rel_in[u]),
            .new_net    (new_net),
            .fast_cand  (fast_c[u]),
            .slow_cand  (slow_c[u]),
            .reuse_q    (reuse_out[u])
        );
        rsw_delay #(.DEPTH(PENALTY)) u_dly (
            .clk       (clk),
            .rst_n     (rst_n),
            .fast_cand (fast_c[u]),
            .slow_cand (slow_c[u]),
            .tok_out   (up_tok[u])
        );
    end

    // Forward an allocate pulse down to the chosen sink-side port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_out <= '0;
        end else begin
            alloc_out <= '0;
            if (|alloc_in) alloc_out[alloc_port] <= 1'b1;
        end
    end

    p_alloc_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_out));

    p_alloc_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|alloc_in) |=> alloc_out[$past(alloc_port)]);

    p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_out != '0) |-> $past(|alloc_in));
endmodule

// File: tb/rsw_cell_bench.sv
module rsw_cell_bench;
    localparam int NDN = 2, NUP = 2, P = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NDN-1:0] srch_in = '0;
    logic srch_clean = 1'b0;
    logic [NUP-1:0] alloc_in = '0;
    logic [0:0] alloc_port = '0;
    logic alloc_lock = 1'b0;
    logic [NUP-1:0] rel_in = '0;
    logic new_net = 1'b0;
    logic [NUP-1:0] up_tok, reuse_out;
    logic [NDN-1:0] alloc_out;

    int total = 0, bad = 0;

    // Reference model state.
    int m_occ[NUP], m_lk[NUP], m_mine[NUP], m_sel[NUP];
    int m_fq[NUP], m_reuse[NUP];
    int m_hist[NUP][P];
    int m_aout[NDN];

    always #2 clk = ~clk;  // 250 MHz

    rsw_cell #(.NDN(NDN), .NUP(NUP), .PENALTY(P)) u_rsw_cell (
        .clk(clk), .rst_n(rst_n), .srch_in(srch_in), .srch_clean(srch_clean),
        .alloc_in(alloc_in), .alloc_port(alloc_port), .alloc_lock(alloc_lock),
        .rel_in(rel_in), .new_net(new_net), .up_tok(up_tok),
        .reuse_out(reuse_out), .alloc_out(alloc_out));

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Step the model with inputs seen at the clock edge just passed.
    task automatic model_step();
        int fc, sc, mt, ot, rs;
        for (int u = 0; u < NUP; u++) begin
            if (!rst_n) begin
                m_occ[u] = 0; m_lk[u] = 0; m_mine[u] = 0; m_sel[u] = 0;
                m_fq[u] = 0; m_reuse[u] = 0;
                for (int k = 0; k < P; k++) m_hist[u][k] = 0;
                continue;
            end
            mt = 0; ot = 0;
            for (int d = 0; d < NDN; d++)
                if (srch_in[d]) begin
                    if (d == m_sel[u]) mt = 1; else ot = 1;
                end
            if (m_occ[u] == 0) begin fc = (srch_in != 0); sc = 0; end
            else begin fc = mt; sc = (ot && !mt && !m_lk[u]); end
            rs = m_occ[u] && m_mine[u] && mt && srch_clean;
            m_fq[u] = fc;
            m_reuse[u] = rs;
            for (int k = P - 1; k > 0; k--) m_hist[u][k] = m_hist[u][k-1];
            m_hist[u][0] = sc;
            if (alloc_in[u]) begin
                m_occ[u] = 1; m_lk[u] = alloc_lock; m_mine[u] = 1;
                m_sel[u] = alloc_port;
            end else begin
                if (rel_in[u]) begin m_occ[u] = 0; m_lk[u] = 0; end
                if (new_net) m_mine[u] = 0;
            end
        end
        for (int d = 0; d < NDN; d++)
            m_aout[d] = rst_n && (alloc_in != 0) && (alloc_port == d);
    endtask

    task automatic compare();
        for (int u = 0; u < NUP; u++) begin
            check($sformatf("R2/R3/R4/R5 up_tok[%0d]", u), up_tok[u],
                  (m_fq[u] || m_hist[u][P-1]) ? 1 : 0);
            check($sformatf("R9/R6/R8 reuse_out[%0d]", u), reuse_out[u], m_reuse[u]);
        end
        for (int d = 0; d < NDN; d++)
            check($sformatf("R7 alloc_out[%0d]", d), alloc_out[d], m_aout[d]);
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1 model_step();
            @(negedge clk);
            compare();
        end
    endtask

    task automatic clear_in();
        alloc_in = '0; rel_in = '0; new_net = 1'b0; alloc_lock = 1'b0;
    endtask

    initial begin
        #200000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total + 1, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        cyc(3);
        // R1: reset state
        check("R1 up_tok", up_tok, 0);
        check("R1 reuse_out", reuse_out, 0);
        check("R1 alloc_out", alloc_out, 0);
        rst_n = 1'b1;
        cyc(2);
        // R2: all links free, token on port 0 and drop
        srch_in = 2'b01; cyc(1);
        check("R2 free link latency", up_tok, 2'b11);
        cyc(2); srch_in = '0; cyc(3);
        // R6/R7: allocate link0 to port0 (unlocked), link1 to port1 (locked)
        alloc_in = 2'b01; alloc_port = 0; cyc(1); clear_in();
        check("R7 alloc to port 0", alloc_out, 2'b01);
        alloc_in = 2'b10; alloc_port = 1; alloc_lock = 1; cyc(1); clear_in();
        check("R7 alloc to port 1", alloc_out, 2'b10);
        cyc(1);
        // R3/R5: token on port 0: link0 agrees, link1 locked conflict
        srch_in = 2'b01; cyc(1);
        check("R3 agreeing link fast", up_tok[0], 1);
        cyc(P + 2);
        check("R5 locked conflict silent", up_tok[1], 0);
        srch_in = '0; cyc(P + 1);
        // R4: token on port 1: link0 conflicts unlocked, delay P
        srch_in = 2'b10; cyc(P - 1);
        check("R4 still delayed", up_tok[0], 0);
        cyc(1);
        check("R4 arrives after penalty", up_tok[0], 1);
        srch_in = '0; cyc(P + 1);
        // R9: clean token on port 0 reuses link0 claimed this net
        srch_clean = 1'b1; srch_in = 2'b01; cyc(1);
        check("R9 reuse on claimed link", reuse_out[0], 1);
        srch_in = '0; cyc(2);
        // R8: new_net together with allocate on link1 (to port 0, unlocked)
        new_net = 1'b1; alloc_in = 2'b10; alloc_port = 0; cyc(1); clear_in();
        srch_in = 2'b01; cyc(1);
        check("R8 cleared link0 no reuse", reuse_out[0], 0);
        check("R8 same-cycle alloc keeps claim", reuse_out[1], 1);
        srch_in = '0; cyc(2);
        // R10: release link1 with allocate on link0 in the same cycle
        rel_in = 2'b10; alloc_in = 2'b01; alloc_port = 1; cyc(1); clear_in();
        srch_in = 2'b01; cyc(1);
        check("R10 released link is free", up_tok[1], 1);
        check("R10 release keeps claim bit", reuse_out[1], 0);
        cyc(P);
        srch_in = '0; cyc(P + 1);
        rel_in = 2'b01; alloc_in = 2'b01; alloc_port = 0; cyc(1); clear_in();
        srch_in = 2'b10; cyc(P - 1);
        check("R10 alloc wins over release", up_tok[0], 0);
        cyc(2);
        // penalty in flight while link0 is released
        srch_in = 2'b10; rel_in = 2'b01; cyc(1); clear_in(); cyc(P + 1);
        srch_in = '0; cyc(P + 2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule